// File: doc/BRIEF.md
# Two-Channel Timer Capture/Compare Unit

A free-running 16-bit up-counter shared by two channels. Each channel either timestamps a chosen edge on its input pin (capture) or raises an event when the counter reaches a programmed value (compare), in which case it also drives its pin and toggles it on each match. Every event sets a per-channel flag. Software reads that flag, and the channel's interrupt request, through an 8-bit register interface. There is one register port, strobed by read and write enables.

The flag can only be cleared by a two-step exchange. Software first reads the control byte while the flag is set. It then writes a zero into the flag bit. Any event that lands between the two steps cancels the clear, so no request is lost. Channel 0 also has a buffered compare mode. In that mode it takes over channel 1's value register as a second compare value. Channel 1's control byte is then switched off, and its pin reverts to general-purpose use.

Top module: `tcc_timer2`

## Requirements
- R1: After reset, both control bytes read 0x00, `irq` is 00 and `pin_oe` is 00.
- R2: The counter starts at 0 after reset and adds one on every clock edge, wrapping from 0xFFFF to 0. A read at address 6 returns its high byte and a read at address 7 returns its low byte. In both cases the value is the one held before the read strobe's clock edge. Read data appears one edge after the strobe.
- R3: The address map is 0/3 = control byte of channel 0/1, 1/4 = value high byte, 2/5 = value low byte. The control byte layout is: bit 7 flag, bit 6 interrupt enable, bit 5 buffered mode (channel 0 only; on channel 1 it reads 0), bit 4 compare select, bits 3:2 pin select, bit 1 and bit 0 plain storage. Writing 1 into bit 7 never sets the flag.
- R4: The flag clears only on a control write with bit 7 = 0 that follows a control read which returned flag = 1. Any control write ends this armed state. A write that has not been armed leaves the flag set.
- R5: If an event occurs after the arming read, the following clearing write has no effect and the flag stays 1.
- R6: `irq[i]` is 1 exactly when channel i's flag and interrupt enable are both 1. It updates on the same edge as the flag.
- R7: With pin select nonzero and compare select 0, the channel captures. Select 01 responds to rising edges, 10 to falling edges and 11 to both. The pin passes through a two-flop synchronizer. Flag and value register update on the third clock edge after the pin changes. The value latched is the counter at the time of the change plus 2.
- R8: With pin select 00, the channel ignores its pin, produces no events and keeps `pin_oe` low.
- R9: With pin select nonzero and compare select 1, `pin_oe` is 1. When the counter equals the value register, the flag is set and `pin_out` toggles on the next edge.
- R10: Buffered mode on channel 0 (bit 5 set, pin select nonzero) compares against channel 0's value register first. At each wrap of the counter it switches to channel 1's value register and back. While buffered mode is set, channel 1's control byte reads 0x00 and ignores writes, and `irq[1]` and `pin_oe[1]` are low.
- R11: The value registers can be written and read back byte by byte at their addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| pin_in | input | 2 | Channel input pins |
| pin_out | output | 2 | Channel compare outputs |
| pin_oe | output | 2 | 1 where a channel owns its pin as an output |
| irq | output | 2 | Per-channel interrupt requests |

## Verification
A flag that is wrongly cleared or stuck shows up on `irq` on the very next edge. It also shows up in bit 7 of the next control read, so the clearing exchange is probed both when armed and when not armed, and with an event placed between its steps. A wrong synchronizer depth or counter latch point shows as a captured value off by one or more counts, or as an interrupt one edge early or late. A broken buffered-compare selection shows as a missing or extra interrupt near the two compare values on opposite sides of a counter wrap.

// File: rtl/tcc_pkg.sv
package tcc_pkg;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = 2 * BYTE_W;

  typedef enum logic [2:0] {
    A_CTL0 = 3'd0, A_V0H = 3'd1, A_V0L = 3'd2,
    A_CTL1 = 3'd3, A_V1H = 3'd4, A_V1L = 3'd5,
    A_CNH  = 3'd6, A_CNL = 3'd7
  } reg_addr_e;

  localparam int B_FLAG = 7;
  localparam int B_IE   = 6;
  localparam int B_BUF  = 5;
  localparam int B_CMP  = 4;
  localparam int B_SELH = 3;
  localparam int B_SELL = 2;
  localparam int B_AUX1 = 1;
  localparam int B_AUX0 = 0;
endpackage

// File: rtl/tcc_count.sv
module tcc_count #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  output logic [W-1:0] cnt,
  output logic         wrap
);
  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else     cnt <= cnt + 1'b1;
  end
  assign wrap = &cnt;
endmodule

// File: rtl/tcc_chan.sv
module tcc_chan
  import tcc_pkg::*;
#(
  parameter bit HAS_BUF     = 1'b0,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic [CNT_W-1:0]  cnt,
  input  logic [CNT_W-1:0]  alt_val,
  input  logic              use_alt,
  input  logic              pin_in,
  input  logic              ctl_rd,
  input  logic              ctl_wr,
  input  logic              vh_wr,
  input  logic              vl_wr,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] ctl_q,
  output logic [CNT_W-1:0]  val_q,
  output logic              flag_o,
  output logic              event_o,
  output logic              irq,
  output logic              pin_out,
  output logic              pin_oe
);
  localparam int SW = SYNC_STAGES + 1;

  logic          flag_q, ie_q, mb_q, ma_q, aux1_q, aux0_q, armed_q;
  logic [1:0]    sel_q;
  logic [SW-1:0] sync_q;
  logic          active, cmp_mode, rise, fall, edge_hit, match, evt;
  logic          flag_n, ie_n, wr_ok;
  logic [CNT_W-1:0] cmp_val;

  always_comb begin
    wr_ok    = ctl_wr && en;
    active   = en && (sel_q != 2'b00);
    cmp_mode = ma_q || mb_q;
    rise     = sync_q[SW-2] && !sync_q[SW-1];
    fall     = !sync_q[SW-2] && sync_q[SW-1];
    edge_hit = active && !cmp_mode && ((sel_q[0] && rise) || (sel_q[1] && fall));
    cmp_val  = (mb_q && use_alt) ? alt_val : val_q;
    match    = active && cmp_mode && (cnt == cmp_val);
    evt      = edge_hit || match;
    ie_n     = wr_ok ? wdata[B_IE] : ie_q;
    if (evt)                                      flag_n = 1'b1;
    else if (wr_ok && armed_q && !wdata[B_FLAG])  flag_n = 1'b0;
    else                                          flag_n = flag_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= 1'b0; ie_q <= 1'b0; mb_q <= 1'b0; ma_q <= 1'b0;
      sel_q <= 2'b00; aux1_q <= 1'b0; aux0_q <= 1'b0; armed_q <= 1'b0;
      sync_q <= '0; val_q <= '0; pin_out <= 1'b0; irq <= 1'b0;
    end else begin
      sync_q <= {sync_q[SW-2:0], pin_in};
      flag_q <= flag_n;
      ie_q   <= ie_n;
      irq    <= flag_n && ie_n && en;
      if (wr_ok) begin
        mb_q   <= HAS_BUF ? wdata[B_BUF] : 1'b0;
        ma_q   <= wdata[B_CMP];
        sel_q  <= wdata[B_SELH:B_SELL];
        aux1_q <= wdata[B_AUX1];
        aux0_q <= wdata[B_AUX0];
      end
      if (evt || wr_ok)                armed_q <= 1'b0;
      else if (ctl_rd && en && flag_q) armed_q <= 1'b1;
      if (edge_hit) val_q <= cnt;
      else begin
        if (vh_wr) val_q[CNT_W-1:BYTE_W] <= wdata;
        if (vl_wr) val_q[BYTE_W-1:0]     <= wdata;
      end
      if (match) pin_out <= !pin_out;
    end
  end

  assign ctl_q   = en ? {flag_q, ie_q, mb_q, ma_q, sel_q, aux1_q, aux0_q} : '0;
  assign pin_oe  = active && cmp_mode;
  assign flag_o  = flag_q;
  assign event_o = evt;
endmodule

// File: rtl/tcc_timer2.sv
module tcc_timer2
  import tcc_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       rd_en,
  input  logic       wr_en,
  input  logic [2:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  input  logic [1:0] pin_in,
  output logic [1:0] pin_out,
  output logic [1:0] pin_oe,
  output logic [1:0] irq
);
  logic [CNT_W-1:0]  cnt, val0, val1;
  logic [BYTE_W-1:0] ctl0, ctl1;
  logic              wrap, buf_on, buf_sel;
  logic [1:0]        flag, ev;

  tcc_count #(.W(CNT_W)) u_cnt (.clk(clk), .rst(rst), .cnt(cnt), .wrap(wrap));

  assign buf_on = ctl0[B_BUF];

  always_ff @(posedge clk) begin
    if (rst || !buf_on) buf_sel <= 1'b0;
    else if (wrap)      buf_sel <= !buf_sel;
  end

  tcc_chan #(.HAS_BUF(1'b1), .SYNC_STAGES(SYNC_STAGES)) u_ch0 (
    .clk(clk), .rst(rst), .en(1'b1), .cnt(cnt), .alt_val(val1), .use_alt(buf_sel),
    .pin_in(pin_in[0]),
    .ctl_rd(rd_en && addr == A_CTL0), .ctl_wr(wr_en && addr == A_CTL0),
    .vh_wr(wr_en && addr == A_V0H), .vl_wr(wr_en && addr == A_V0L),
    .wdata(wdata), .ctl_q(ctl0), .val_q(val0), .flag_o(flag[0]), .event_o(ev[0]),
    .irq(irq[0]), .pin_out(pin_out[0]), .pin_oe(pin_oe[0]));

  tcc_chan #(.HAS_BUF(1'b0), .SYNC_STAGES(SYNC_STAGES)) u_ch1 (
    .clk(clk), .rst(rst), .en(!buf_on), .cnt(cnt), .alt_val('0), .use_alt(1'b0),
    .pin_in(pin_in[1]),
    .ctl_rd(rd_en && addr == A_CTL1), .ctl_wr(wr_en && addr == A_CTL1),
    .vh_wr(wr_en && addr == A_V1H), .vl_wr(wr_en && addr == A_V1L),
    .wdata(wdata), .ctl_q(ctl1), .val_q(val1), .flag_o(flag[1]), .event_o(ev[1]),
    .irq(irq[1]), .pin_out(pin_out[1]), .pin_oe(pin_oe[1]));

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else if (rd_en) begin
      case (addr)
        A_CTL0:  rdata <= ctl0;
        A_V0H:   rdata <= val0[CNT_W-1:BYTE_W];
        A_V0L:   rdata <= val0[BYTE_W-1:0];
        A_CTL1:  rdata <= ctl1;
        A_V1H:   rdata <= val1[CNT_W-1:BYTE_W];
        A_V1L:   rdata <= val1[BYTE_W-1:0];
        A_CNH:   rdata <= cnt[CNT_W-1:BYTE_W];
        default: rdata <= cnt[BYTE_W-1:0];
      endcase
    end
  end
endmodule

// File: rtl/tcc_timer2_chk.sv
module tcc_timer2_chk (
  input logic       clk,
  input logic       rst,
  input logic       wr_en,
  input logic [2:0] addr,
  input logic [7:0] wdata,
  input logic [1:0] irq,
  input logic [1:0] pin_out,
  input logic [1:0] pin_oe,
  input logic [1:0] flag,
  input logic [1:0] ev,
  input logic       buf_on
);
  for (genvar i = 0; i < 2; i++) begin : g_ch
    // R4: flag only drops after a clearing write to its control byte
    p_clear_path_r4: assert property (@(posedge clk) disable iff (rst)
      $fell(flag[i]) |-> $past(wr_en && addr == 3'(i * 3) && !wdata[7]));
    // R5: an event always leaves the flag set on the next edge
    p_event_wins_r5: assert property (@(posedge clk) disable iff (rst)
      $past(ev[i]) |-> flag[i]);
    // R6: request implies flag
    p_irq_gated_r6: assert property (@(posedge clk) disable iff (rst)
      irq[i] |-> flag[i]);
    // R9: output only moves while the channel drives it
    p_out_quiet_r9: assert property (@(posedge clk) disable iff (rst)
      $past(!pin_oe[i]) |-> $stable(pin_out[i]));
  end
  // R10: channel 1 silenced in buffered mode
  p_ch1_irq_off_r10: assert property (@(posedge clk) disable iff (rst)
    $past(buf_on) |-> !irq[1]);
  p_ch1_pin_off_r10: assert property (@(posedge clk) disable iff (rst)
    buf_on |-> !pin_oe[1]);
endmodule

bind tcc_timer2 tcc_timer2_chk u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .irq(irq), .pin_out(pin_out), .pin_oe(pin_oe), .flag(flag), .ev(ev),
  .buf_on(buf_on));

// File: tb/sim_tcc_timer2.sv
module sim_tcc_timer2;
  logic       clk = 1'b0, rst = 1'b1, rd_en = 1'b0, wr_en = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0, rdata;
  logic [1:0] pin_in = '0, pin_out, pin_oe, irq;
  logic [15:0] mcnt;
  logic        rd_q;
  int          n_run = 0, n_fail = 0;
  bit          done = 1'b0;
  logic [7:0]  exp_q[$];
  string       tag_q[$];

  always #2 clk = ~clk;

  tcc_timer2 u0 (.clk(clk), .rst(rst), .rd_en(rd_en), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .pin_in(pin_in), .pin_out(pin_out),
    .pin_oe(pin_oe), .irq(irq));

  // independent model of the free-running counter
  always @(posedge clk) begin
    if (rst) mcnt <= '0; else mcnt <= mcnt + 16'd1;
    rd_q <= rd_en;
  end

  // monitor: compare read data against the scoreboard queue
  always @(negedge clk) begin
    if (rd_q && exp_q.size() > 0) begin
      logic [7:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      n_run++;
      if (rdata !== e) begin
        n_fail++;
        $display("FAIL %s rdata actual %02h expected %02h", t, rdata, e);
      end
    end
  end

  task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string t);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual %0h expected %0h", t, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [7:0] e, input string t);
    rd_en = 1'b1; addr = a;
    exp_q.push_back(e); tag_q.push_back(t);
    @(posedge clk); @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic wait_cnt(input logic [15:0] v);
    while (mcnt != v) @(negedge clk);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [15:0] c, tgt;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    idle(1);
    // R1 reset state
    chk({14'd0, irq}, 16'd0, "R1 irq");
    chk({14'd0, pin_oe}, 16'd0, "R1 pin_oe");
    rd(3'd0, 8'h00, "R1 ctl0");
    rd(3'd3, 8'h00, "R1 ctl1");
    // R2 counter
    rd(3'd7, mcnt[7:0], "R2 cnt lo");
    rd(3'd6, mcnt[15:8], "R2 cnt hi");
    // R11 value bytes, R3 layout (ch1 bit5 reads 0, bit7 write ignored)
    wr(3'd1, 8'h12); wr(3'd2, 8'h34);
    rd(3'd1, 8'h12, "R11 v0 hi"); rd(3'd2, 8'h34, "R11 v0 lo");
    wr(3'd3, 8'hFF);
    rd(3'd3, 8'h5F, "R3 ctl1 layout");
    wr(3'd3, 8'h00);
    // R7 capture rising, R6 irq timing
    wr(3'd0, 8'h44);
    c = mcnt; pin_in[0] = 1'b1;
    idle(2);
    chk({15'd0, irq[0]}, 16'd0, "R7 not before third edge");
    idle(1);
    chk({15'd0, irq[0]}, 16'd1, "R6 R7 irq on third edge");
    rd(3'd1, 8'((c + 16'd2) >> 8), "R7 capture hi");
    rd(3'd2, 8'(c + 16'd2), "R7 capture lo");
    // R4 unarmed write leaves flag
    wr(3'd0, 8'h44);
    rd(3'd0, 8'hC4, "R4 unarmed keeps flag");
    wr(3'd0, 8'hC4);
    rd(3'd0, 8'hC4, "R4 write one no clear");
    wr(3'd0, 8'h44);
    rd(3'd0, 8'h44, "R4 armed clear");
    chk({15'd0, irq[0]}, 16'd0, "R6 irq drops");
    // R7 falling edge ignored in rising mode
    pin_in[0] = 1'b0; idle(5);
    rd(3'd0, 8'h44, "R7 falling ignored");
    // R5 event between read and write
    pin_in[0] = 1'b1; idle(5);
    pin_in[0] = 1'b0; idle(5);
    rd(3'd0, 8'hC4, "R5 arm read");
    c = mcnt; pin_in[0] = 1'b1; idle(5);
    wr(3'd0, 8'h44);
    rd(3'd0, 8'hC4, "R5 clear cancelled");
    rd(3'd2, 8'(c + 16'd2), "R5 new capture lo");
    rd(3'd0, 8'hC4, "R5 rearm");
    wr(3'd0, 8'h44);
    rd(3'd0, 8'h44, "R5 later clear");
    // R7 both edges: falling captured
    wr(3'd0, 8'h4C);
    c = mcnt; pin_in[0] = 1'b0; idle(4);
    rd(3'd0, 8'hCC, "R7 both-edge flag");
    rd(3'd2, 8'(c + 16'd2), "R7 falling capture lo");
    wr(3'd0, 8'h4C);
    // R8 disconnected
    wr(3'd0, 8'h40);
    pin_in[0] = 1'b1; idle(5); pin_in[0] = 1'b0; idle(5);
    rd(3'd0, 8'h40, "R8 no event");
    chk({15'd0, pin_oe[0]}, 16'd0, "R8 pin_oe");
    // R9 compare on channel 1
    tgt = mcnt + 16'd40;
    wr(3'd4, tgt[15:8]); wr(3'd5, tgt[7:0]);
    wr(3'd3, 8'h5C);
    chk({15'd0, pin_oe[1]}, 16'd1, "R9 pin_oe");
    wait_cnt(tgt);
    chk({14'd0, irq[1], pin_out[1]}, 16'd0, "R9 before match");
    idle(1);
    chk({14'd0, irq[1], pin_out[1]}, 16'd3, "R9 match irq and toggle");
    rd(3'd3, 8'hDC, "R9 flag");
    wr(3'd3, 8'h5C);
    // R10 buffered mode
    wr(3'd1, 8'h80); wr(3'd2, 8'h00);
    wr(3'd4, 8'h01); wr(3'd5, 8'h00);
    wr(3'd0, 8'h7C);
    rd(3'd3, 8'h00, "R10 ch1 reads zero");
    wr(3'd3, 8'h00);
    chk({14'd0, pin_oe[1], irq[1]}, 16'd0, "R10 ch1 pin and irq low");
    wait_cnt(16'h8000);
    chk({15'd0, irq[0]}, 16'd0, "R10 before first value");
    idle(1);
    chk({15'd0, irq[0]}, 16'd1, "R10 first value match");
    rd(3'd0, 8'hFC, "R10 flag");
    wr(3'd0, 8'h7C);
    wait_cnt(16'hFFF0);
    chk({15'd0, irq[0]}, 16'd0, "R10 quiet before wrap");
    wait_cnt(16'h0100);
    chk({15'd0, irq[0]}, 16'd0, "R10 before second value");
    idle(1);
    chk({15'd0, irq[0]}, 16'd1, "R10 alternate value match");
    wr(3'd0, 8'h00);
    rd(3'd3, 8'h5C, "R10 ch1 write was ignored");
    idle(2);
    finish_run();
  end
endmodule